// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block is a hardware loop. It takes one operation written in scalar form, with a destination register and two source registers, and turns it into a series of scalar micro-ops, one for each active vector element. Each register carries a "vectorised" tag. A tagged register steps through consecutive registers as the element index advances. An untagged register is reused for every element. This one mechanism covers the scalar-scalar, scalar-vector and vector-vector forms.

Predication comes from a small associative table. The table is searched with the regfile selector and the destination register number. A hit names an integer register whose bits act as a per-element enable mask, and the hit can also request that the mask be inverted. Elements whose enable bit is clear are skipped. No micro-op is produced for them, so their destination register keeps its old value. The loop length is the smaller of the global vector length and the length configured for the destination. Both are capped at the mask width XLEN. When the loop ends, a one-cycle done pulse is given.

Top module: `vec_elem_seq`

## Requirements
- R1: The loop runs over indices 0 to B-1, where B = min(min(globalVl, XLEN), min(opRdLen, XLEN)). No micro-op is issued with an index of B or higher.
- R2: A micro-op with uopIdx = i is issued if and only if bit i of the effective mask is 1. Elements whose bit is 0 are skipped and produce no micro-op. Micro-ops come out in ascending index order.
- R3: For element i, the micro-op carries uopRd = (opRd + (vecTag[opRd] ? i : 0)) mod 32. uopRs1 and uopRs2 are formed the same way, each from its own base register and its own tag.
- R4: Each of the N table entries has a valid bit, a 1-bit regfile selector (tblFp), a 5-bit key (tblKey) and a 5-bit predicate register (tblPred). Entry e occupies bits [5e+4:5e] of the packed key and predicate buses. An entry hits when it is valid, its selector equals opFp and its key equals opRd. If several entries hit, the lowest-numbered one wins, and its predicate register is read through predAddr.
- R5: If the winning entry has tblInv set, the predicate word is bitwise complemented before the element test.
- R6: If no entry hits, the effective mask is all ones.
- R7: done is high for exactly one cycle after the last index, including when B = 0. With uopReady held high, done goes high on the (B+2)-th rising edge after the edge that accepted the operation.
- R8: opReady is high only while the sequencer is idle. An opValid presented while busy has no effect on the micro-ops in progress.
- R9: While uopValid is high and uopReady is low, uopValid stays high and uopRd, uopRs1, uopRs2 and uopIdx are held steady. At most one element advances per cycle.
- R10: A globalVl or opRdLen value above XLEN is treated as XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation offered |
| opReady | output | 1 | Sequencer idle, operation accepted this cycle |
| opFp | input | 1 | Regfile selector of the operation (1 = FP) |
| opRd | input | 5 | Destination base register |
| opRs1 | input | 5 | First source base register |
| opRs2 | input | 5 | Second source base register |
| opRdLen | input | 5 | Vector length configured for the destination |
| globalVl | input | 5 | Global vector length |
| vecTag | input | 32 | Per-register vectorised tags |
| tblValid | input | 4 | Table entry valid bits |
| tblFp | input | 4 | Table entry regfile selectors |
| tblKey | input | 20 | Packed table keys, 5 bits per entry |
| tblPred | input | 20 | Packed predicate register numbers, 5 bits per entry |
| tblInv | input | 4 | Table entry invert flags |
| predAddr | output | 5 | Integer register read for the predicate |
| predData | input | 16 | Contents of the register at predAddr |
| uopValid | output | 1 | Micro-op valid |
| uopReady | input | 1 | Micro-op accepted |
| uopRd | output | 5 | Micro-op destination register |
| uopRs1 | output | 5 | Micro-op first source register |
| uopRs2 | output | 5 | Micro-op second source register |
| uopIdx | output | 5 | Element index of the micro-op |
| done | output | 1 | One-cycle end-of-loop pulse |

## Verification
The bench sweeps the global length from 0 up past XLEN, and also sweeps the destination length. These sweeps show whether the loop bound takes the minimum of the two and applies the cap, and they time the done pulse at every length, including zero. All eight tag combinations run with and without inversion and under a stalling ready. This separates per-operand offset stepping from shared stepping, mask polarity, and holding the output while stalled. Further cases check the table lookup: several entries hitting at once, a selector mismatch, an invalid entry, and register-number wrap past 31. A final case drives opValid with other fields while the sequencer is busy and shows that the micro-ops in progress are unaffected.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef struct packed {
    logic load;
    logic grab;
    logic step;
  } seqStrb_t;

  typedef struct packed {
    logic atEnd;
    logic curActive;
  } seqStat_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_RUN   = 2'd2,
    S_FIN   = 2'd3
  } seqState_t;
endpackage

// File: rtl/vseq_lookup.sv
module vseq_lookup #(
  parameter int N_ENT = 4,
  parameter int REG_W = 5
) (
  input  logic                   qFp,
  input  logic [REG_W-1:0]       qKey,
  input  logic [N_ENT-1:0]       tblValid,
  input  logic [N_ENT-1:0]       tblFp,
  input  logic [N_ENT*REG_W-1:0] tblKey,
  input  logic [N_ENT*REG_W-1:0] tblPred,
  input  logic [N_ENT-1:0]       tblInv,
  output logic                   hit,
  output logic [REG_W-1:0]       predReg,
  output logic                   inv
);
  logic [N_ENT-1:0] hitVec;

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    assign hitVec[e] = tblValid[e] && (tblFp[e] == qFp) &&
                       (tblKey[e*REG_W +: REG_W] == qKey);
  end

  // scan from the top so that the lowest-numbered hit is written last
  always_comb begin
    hit     = 1'b0;
    predReg = '0;
    inv     = 1'b0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (hitVec[e]) begin
        hit     = 1'b1;
        predReg = tblPred[e*REG_W +: REG_W];
        inv     = tblInv[e];
      end
    end
  end
endmodule

// File: rtl/vseq_datapath.sv
module vseq_datapath
  import vseq_pkg::*;
#(
  parameter int XLEN  = 16,
  parameter int REG_W = 5,
  parameter int N_ENT = 4,
  parameter int IDX_W = $clog2(XLEN + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrb_t               strb,
  input  logic                   opFp,
  input  logic [REG_W-1:0]       opRd,
  input  logic [REG_W-1:0]       opRs1,
  input  logic [REG_W-1:0]       opRs2,
  input  logic [IDX_W-1:0]       opRdLen,
  input  logic [IDX_W-1:0]       globalVl,
  input  logic [(1<<REG_W)-1:0]  vecTag,
  input  logic [N_ENT-1:0]       tblValid,
  input  logic [N_ENT-1:0]       tblFp,
  input  logic [N_ENT*REG_W-1:0] tblKey,
  input  logic [N_ENT*REG_W-1:0] tblPred,
  input  logic [N_ENT-1:0]       tblInv,
  output logic [REG_W-1:0]       predAddr,
  input  logic [XLEN-1:0]        predData,
  output logic [REG_W-1:0]       uopRd,
  output logic [REG_W-1:0]       uopRs1,
  output logic [REG_W-1:0]       uopRs2,
  output logic [IDX_W-1:0]       uopIdx,
  output seqStat_t               stat
);
  localparam logic [IDX_W-1:0] XLEN_V = IDX_W'(XLEN);
  localparam int BIT_W = $clog2(XLEN);

  logic             lkHit, lkInv;
  logic [REG_W-1:0] lkPred;

  vseq_lookup #(.N_ENT(N_ENT), .REG_W(REG_W)) i_lookup (
    .qFp     (opFp),
    .qKey    (opRd),
    .tblValid(tblValid),
    .tblFp   (tblFp),
    .tblKey  (tblKey),
    .tblPred (tblPred),
    .tblInv  (tblInv),
    .hit     (lkHit),
    .predReg (lkPred),
    .inv     (lkInv)
  );

  logic [REG_W-1:0] rdBase, rs1Base, rs2Base;
  logic [REG_W-1:0] offRd, offRs1, offRs2;
  logic             vecRd, vecRs1, vecRs2;
  logic             hasPred, invSel;
  logic [REG_W-1:0] predSel;
  logic [XLEN-1:0]  mask;
  logic [IDX_W-1:0] idx, bound;
  logic [IDX_W-1:0] vlCap, lenCap, boundNext;

  always_comb begin
    vlCap     = (globalVl > XLEN_V) ? XLEN_V : globalVl;
    lenCap    = (opRdLen > XLEN_V) ? XLEN_V : opRdLen;
    boundNext = (vlCap < lenCap) ? vlCap : lenCap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdBase  <= '0;
      rs1Base <= '0;
      rs2Base <= '0;
      vecRd   <= 1'b0;
      vecRs1  <= 1'b0;
      vecRs2  <= 1'b0;
      hasPred <= 1'b0;
      invSel  <= 1'b0;
      predSel <= '0;
      bound   <= '0;
    end else if (strb.load) begin
      rdBase  <= opRd;
      rs1Base <= opRs1;
      rs2Base <= opRs2;
      vecRd   <= vecTag[opRd];
      vecRs1  <= vecTag[opRs1];
      vecRs2  <= vecTag[opRs2];
      hasPred <= lkHit;
      invSel  <= lkInv;
      predSel <= lkPred;
      bound   <= boundNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask <= '0;
    end else if (strb.grab) begin
      if (!hasPred) mask <= '1;
      else if (invSel) mask <= ~predData;
      else mask <= predData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.load) begin
      idx    <= '0;
      offRd  <= '0;
      offRs1 <= '0;
      offRs2 <= '0;
    end else if (strb.step) begin
      idx <= idx + 1'b1;
      if (vecRd)  offRd  <= offRd + 1'b1;
      if (vecRs1) offRs1 <= offRs1 + 1'b1;
      if (vecRs2) offRs2 <= offRs2 + 1'b1;
    end
  end

  assign predAddr       = predSel;
  assign uopRd          = rdBase + offRd;
  assign uopRs1         = rs1Base + offRs1;
  assign uopRs2         = rs2Base + offRs2;
  assign uopIdx         = idx;
  assign stat.atEnd     = (idx == bound);
  assign stat.curActive = mask[idx[BIT_W-1:0]];

  AST_IDX_IN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |-> idx <= bound); // R1
  AST_NO_STEP_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> idx < bound); // R1
  AST_VEC_OFF_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (vecRd && !strb.load) |-> offRd == REG_W'(idx)); // R3
  AST_SCALAR_OFF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!vecRs1 && !strb.load) |-> offRs1 == '0); // R3
  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(rdBase) && $stable(bound)); // R8
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     opValid,
  output logic     opReady,
  input  logic     uopReady,
  output logic     uopValid,
  output logic     done,
  input  seqStat_t stat,
  output seqStrb_t strb
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (opValid) stateNext = S_FETCH;
      S_FETCH: stateNext = S_RUN;
      S_RUN:   if (stat.atEnd) stateNext = S_FIN;
      S_FIN:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else state <= stateNext;
  end

  assign opReady   = (state == S_IDLE);
  assign uopValid  = (state == S_RUN) && !stat.atEnd && stat.curActive;
  assign done      = (state == S_FIN);
  assign strb.load = opReady && opValid;
  assign strb.grab = (state == S_FETCH);
  assign strb.step = (state == S_RUN) && !stat.atEnd &&
                     (!stat.curActive || uopReady);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_UOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && !uopReady) |=> uopValid); // R9
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |=> !$rose(opReady) || $past(done)); // R8
  AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(state) == S_RUN); // R7
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int XLEN  = 16,
  parameter int REG_W = 5,
  parameter int N_ENT = 4,
  parameter int IDX_W = $clog2(XLEN + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   opValid,
  output logic                   opReady,
  input  logic                   opFp,
  input  logic [REG_W-1:0]       opRd,
  input  logic [REG_W-1:0]       opRs1,
  input  logic [REG_W-1:0]       opRs2,
  input  logic [IDX_W-1:0]       opRdLen,
  input  logic [IDX_W-1:0]       globalVl,
  input  logic [(1<<REG_W)-1:0]  vecTag,
  input  logic [N_ENT-1:0]       tblValid,
  input  logic [N_ENT-1:0]       tblFp,
  input  logic [N_ENT*REG_W-1:0] tblKey,
  input  logic [N_ENT*REG_W-1:0] tblPred,
  input  logic [N_ENT-1:0]       tblInv,
  output logic [REG_W-1:0]       predAddr,
  input  logic [XLEN-1:0]        predData,
  output logic                   uopValid,
  input  logic                   uopReady,
  output logic [REG_W-1:0]       uopRd,
  output logic [REG_W-1:0]       uopRs1,
  output logic [REG_W-1:0]       uopRs2,
  output logic [IDX_W-1:0]       uopIdx,
  output logic                   done
);
  seqStrb_t strb;
  seqStat_t stat;

  vseq_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opReady (opReady),
    .uopReady(uopReady),
    .uopValid(uopValid),
    .done    (done),
    .stat    (stat),
    .strb    (strb)
  );

  vseq_datapath #(.XLEN(XLEN), .REG_W(REG_W), .N_ENT(N_ENT), .IDX_W(IDX_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .opFp    (opFp),
    .opRd    (opRd),
    .opRs1   (opRs1),
    .opRs2   (opRs2),
    .opRdLen (opRdLen),
    .globalVl(globalVl),
    .vecTag  (vecTag),
    .tblValid(tblValid),
    .tblFp   (tblFp),
    .tblKey  (tblKey),
    .tblPred (tblPred),
    .tblInv  (tblInv),
    .predAddr(predAddr),
    .predData(predData),
    .uopRd   (uopRd),
    .uopRs1  (uopRs1),
    .uopRs2  (uopRs2),
    .uopIdx  (uopIdx),
    .stat    (stat)
  );
endmodule

// File: tb/test_vec_elem_seq.sv
module test_vec_elem_seq;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 16;
  localparam int N_ENT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0, opReady, opFp = 1'b0;
  logic [4:0] opRd = '0, opRs1 = '0, opRs2 = '0, opRdLen = '0, globalVl = '0;
  logic [31:0] vecTag = '0;
  logic [N_ENT-1:0] tblValid, tblFp, tblInv;
  logic [N_ENT*5-1:0] tblKey, tblPred;
  logic [4:0] predAddr;
  logic [XLEN-1:0] predData;
  logic uopValid, uopReady = 1'b0, done;
  logic [4:0] uopRd, uopRs1, uopRs2, uopIdx;

  logic [XLEN-1:0] regs [32];
  logic tV [N_ENT];
  logic tF [N_ENT];
  logic tI [N_ENT];
  logic [4:0] tK [N_ENT];
  logic [4:0] tP [N_ENT];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int e = 0; e < N_ENT; e++) begin
      tblValid[e] = tV[e];
      tblFp[e]    = tF[e];
      tblInv[e]   = tI[e];
      tblKey[e*5 +: 5]  = tK[e];
      tblPred[e*5 +: 5] = tP[e];
    end
  end
  assign predData = regs[predAddr];

  vec_elem_seq i_vec_elem_seq (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady), .opFp(opFp),
    .opRd(opRd), .opRs1(opRs1), .opRs2(opRs2), .opRdLen(opRdLen),
    .globalVl(globalVl), .vecTag(vecTag), .tblValid(tblValid), .tblFp(tblFp),
    .tblKey(tblKey), .tblPred(tblPred), .tblInv(tblInv), .predAddr(predAddr),
    .predData(predData), .uopValid(uopValid), .uopReady(uopReady),
    .uopRd(uopRd), .uopRs1(uopRs1), .uopRs2(uopRs2), .uopIdx(uopIdx), .done(done)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic clearTable();
    for (int e = 0; e < N_ENT; e++) begin
      tV[e] = 1'b0; tF[e] = 1'b0; tI[e] = 1'b0; tK[e] = '0; tP[e] = '0;
    end
  endtask

  function automatic logic [XLEN-1:0] expMask(input logic fp, input logic [4:0] rd);
    for (int e = 0; e < N_ENT; e++)
      if (tV[e] && tF[e] == fp && tK[e] == rd)
        return tI[e] ? ~regs[tP[e]] : regs[tP[e]];
    return '1;
  endfunction

  task automatic runOp(input logic fp, input int rd, input int rs1, input int rs2,
                       input int rdLen, input int vl, input logic [2:0] tags,
                       input bit stall, input bit noise);
    int capVl, capLen, bnd, nExp, fires, k, doneK;
    int expRd [XLEN];
    int expR1 [XLEN];
    int expR2 [XLEN];
    int expIx [XLEN];
    logic [XLEN-1:0] m;
    logic rdy, hold;
    logic [4:0] hRd, hR1, hR2, hIx;
    capVl  = (vl > XLEN) ? XLEN : vl;
    capLen = (rdLen > XLEN) ? XLEN : rdLen;
    bnd    = (capVl < capLen) ? capVl : capLen;
    m      = expMask(fp, 5'(rd));
    nExp   = 0;
    for (int i = 0; i < bnd; i++) begin
      if (m[i]) begin
        expRd[nExp] = (rd  + (tags[0] ? i : 0)) % 32;
        expR1[nExp] = (rs1 + (tags[1] ? i : 0)) % 32;
        expR2[nExp] = (rs2 + (tags[2] ? i : 0)) % 32;
        expIx[nExp] = i;
        nExp++;
      end
    end
    @(negedge clk);
    vecTag = '0;
    vecTag[rd] = tags[0]; vecTag[rs1] = tags[1]; vecTag[rs2] = tags[2];
    opFp = fp; opRd = 5'(rd); opRs1 = 5'(rs1); opRs2 = 5'(rs2);
    opRdLen = 5'(rdLen); globalVl = 5'(vl); opValid = 1'b1;
    chk("R8 opReady when idle", int'(opReady), 1);
    @(negedge clk);
    if (noise) begin
      opRd = 5'(rd ^ 5); opRs1 = 5'(rs1 ^ 3); globalVl = 5'd1;
    end else begin
      opValid = 1'b0;
    end
    fires = 0; k = 0; doneK = -1; hold = 1'b0;
    hRd = '0; hR1 = '0; hR2 = '0; hIx = '0;
    while (doneK < 0 && k < 400) begin
      k++;
      if (k == 1) chk("R8 opReady while busy", int'(opReady), 0);
      if (hold) begin
        chk("R9 valid held", int'(uopValid), 1);
        chk("R9 rd held", int'(uopRd), int'(hRd));
        chk("R9 rs1 held", int'(uopRs1), int'(hR1));
        chk("R9 rs2 held", int'(uopRs2), int'(hR2));
        chk("R9 idx held", int'(uopIdx), int'(hIx));
      end
      if (done) begin
        doneK = k;
      end else begin
        rdy = stall ? ((k % 3) != 0) : 1'b1;
        uopReady = rdy;
        if (uopValid && rdy) begin
          if (fires < nExp) begin
            chk("R2 issued index", int'(uopIdx), expIx[fires]);
            chk("R3 uopRd", int'(uopRd), expRd[fires]);
            chk("R3 uopRs1", int'(uopRs1), expR1[fires]);
            chk("R3 uopRs2", int'(uopRs2), expR2[fires]);
          end
          fires++;
        end
        hold = uopValid && !rdy;
        hRd = uopRd; hR1 = uopRs1; hR2 = uopRs2; hIx = uopIdx;
        @(negedge clk);
      end
    end
    if (noise) opValid = 1'b0;
    if (doneK < 0) begin
      errors++;
      $display("FAIL R7 watchdog: done never seen, actual 0 expected 1");
    end
    chk("R1 R2 micro-op count", fires, nExp);
    if (!stall) chk("R7 done latency", doneK, bnd + 3);
    uopReady = 1'b0;
    @(negedge clk);
    chk("R7 done is one pulse", int'(done), 0);
    chk("R8 idle after done", int'(opReady), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) regs[r] = 16'(r * 16'h9E37 + 16'h1234);
    clearTable();
    repeat (3) @(negedge clk);
    chk("reset opReady", int'(opReady), 1);
    chk("reset uopValid", int'(uopValid), 0);
    chk("reset done", int'(done), 0);
    rstN = 1'b1;

    // R1 R10 R6 R7: global length sweep, no table entry, all vectorised
    for (int v = 0; v <= 20; v++) runOp(1'b0, 2, 8, 20, 16, v, 3'b111, 1'b0, 1'b0);
    // R1 R10: destination length sweep
    for (int l = 0; l <= 18; l++) runOp(1'b0, 4, 9, 12, l, 10, 3'b111, 1'b0, 1'b0);

    // R2 R3 R4 R5 R9: predicated, every tag combination, both polarities, stalls
    regs[7] = 16'b1011_0010_1100_1101;
    for (int t = 0; t < 8; t++)
      for (int inv = 0; inv < 2; inv++)
        for (int s = 0; s < 2; s++) begin
          clearTable();
          tV[1] = 1'b1; tF[1] = 1'b0; tK[1] = 5'd3; tP[1] = 5'd7; tI[1] = inv[0];
          runOp(1'b0, 3, 11, 21, 16, 16, 3'(t), s[0], 1'b0);
        end

    // R4: two entries hit, lowest index wins
    clearTable();
    regs[5] = 16'h00F0; regs[6] = 16'h0F0F;
    tV[2] = 1'b1; tK[2] = 5'd10; tP[2] = 5'd6;
    tV[3] = 1'b1; tK[3] = 5'd10; tP[3] = 5'd5; tI[3] = 1'b1;
    runOp(1'b0, 10, 1, 2, 16, 12, 3'b101, 1'b0, 1'b0);
    // R4 R6: selector mismatch and invalid entry both miss, all active
    clearTable();
    tV[0] = 1'b1; tF[0] = 1'b1; tK[0] = 5'd10; tP[0] = 5'd6;
    tV[1] = 1'b0; tF[1] = 1'b0; tK[1] = 5'd10; tP[1] = 5'd5;
    runOp(1'b0, 10, 1, 2, 16, 9, 3'b011, 1'b0, 1'b0);
    // R4: FP selector matches an FP entry
    runOp(1'b1, 10, 1, 2, 16, 9, 3'b011, 1'b1, 1'b0);
    // R3: register number wraps past 31
    clearTable();
    runOp(1'b0, 30, 29, 5, 8, 8, 3'b111, 1'b0, 1'b0);
    // R8: busy sequencer ignores a new opValid with other fields
    regs[9] = 16'h5A5A;
    tV[0] = 1'b1; tK[0] = 5'd14; tP[0] = 5'd9;
    runOp(1'b0, 14, 16, 24, 16, 11, 3'b110, 1'b1, 1'b1);
    // R2: empty mask issues nothing
    regs[9] = 16'h0000;
    runOp(1'b0, 14, 16, 24, 16, 16, 3'b111, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule